// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Almost-Empty Flag

This block is a FIFO whose write and read sides run on separate clocks. The read side works in one of two timings, chosen by a static mode input. In standard timing, each enabled read places the next stored word on the read data bus, so the consumer captures it one edge later. In fall-through timing, the oldest word is already on the bus before any read, and each enabled read moves on to the word after it. Both timings share one output register and one read pointer.

On the read side the block drives one status flag, `rd_flag_o`. In standard timing it is an active-low empty indication: high means stored data is waiting. In fall-through timing it means the output register holds a valid word. An active-low almost-empty flag compares the number of words in the storage array with an offset that is captured at reset. In fall-through timing the word held in the output register is not counted. On the write side the block drives a full flag and a sticky overflow flag. The pointers cross between the clock domains as Gray codes, each through a two-stage synchronizer.

Top module: `dcf_fifo`

## Requirements
- R1: In standard mode (mode input 0), an enabled read with data stored drives the oldest stored word onto `rd_data_o` at that read-clock edge. Words come out in the order they were written.
- R2: In fall-through mode (mode input 1), the oldest word is on `rd_data_o` with `rd_flag_o` high before any read. Each enabled read replaces it with the next word, so N words are consumed in N enabled reads.
- R3: In fall-through mode, after a write into an empty FIFO, `rd_flag_o` rises on the third read-clock edge. The first word appears on `rd_data_o` at that same edge.
- R4: In standard mode, after a write into an empty FIFO, `rd_flag_o` goes high on the third read-clock edge. It stays high until reads have removed every stored word, and `rd_data_o` does not change before a read.
- R5: `ae_n_o` is low while the array count seen by the read side is at most the offset X. It is high once that count reaches X+1. The array count excludes the word held in the output register in fall-through mode, so N writes give N words in standard mode and N-1 in fall-through mode.
- R6: With `ae_n_o` high, a read that takes the array count from X+1 to X drives `ae_n_o` low at that read edge.
- R7: `full_o` is high when the array holds DEPTH words. A write while full is dropped, and it sets `overflow_o`, which stays high until reset.
- R8: A read while nothing is stored, or while `rd_flag_o` is low in fall-through mode, is ignored and leaves `rd_data_o` unchanged.
- R9: The mode input and `ae_offset_i` are captured only while the block is in reset. Changing them afterwards has no effect until the next reset.
- R10: After reset, `rd_flag_o`, `ae_n_o`, `full_o`, `overflow_o` and `rd_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| fwft_mode_i | input | 1 | Read timing select: 0 standard, 1 fall-through; captured in reset |
| ae_offset_i | input | $clog2(DEPTH)+1 | Almost-empty offset X; captured in reset |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | DW | Write data |
| full_o | output | 1 | Array holds DEPTH words |
| overflow_o | output | 1 | Sticky: a write arrived while full |
| rd_en_i | input | 1 | Read enable |
| rd_data_o | output | DW | Read data register |
| rd_flag_o | output | 1 | Standard mode: active-low empty; fall-through mode: output ready |
| ae_n_o | output | 1 | Active-low almost-empty |

## Verification
In fall-through mode a single read-clock edge can carry an enabled read, the reload of the output register from the array, and a new almost-empty decision based on the count after that reload. The bench sets this up with offset 4 and seven writes, then reads twice so that the second read crosses from five array words to four. After each edge it checks that the next word is on the bus and that the flag is still high after the first read and low after the second. A second overlap is the read that empties the FIFO: that edge both delivers the last word and drops `rd_flag_o`. The bench checks both results after that edge in each mode.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the XOR of all gray bits at or above it
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_o[i] = ^(sync_q >> i);
    end
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rbin_s_i,
  output logic          wr_ok_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          overflow_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wptr_q, wptr_n, wgray_q, wgray_n, wcnt;
  logic          ovf_q, ovf_n;

  always_comb begin
    wcnt    = wptr_q - rbin_s_i;
    full_o  = (wcnt == DEPTH_P);
    wr_ok_o = wr_en_i && !full_o;
    wptr_n  = wptr_q + PW'(wr_ok_o);
    wgray_n = (wptr_n >> 1) ^ wptr_n;
    ovf_n   = ovf_q || (wr_en_i && full_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_n;
      wgray_q <= wgray_n;
      ovf_q   <= ovf_n;
    end
  end

  assign waddr_o    = wptr_q[AW-1:0];
  assign wgray_o    = wgray_q;
  assign overflow_o = ovf_q;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && full_o) |=> $stable(wptr_q));
  p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  p_gray_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray_q ^ $past(wgray_q)));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter  int DW    = 36,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          rst_n,
  input  logic          fwft_i,
  input  logic [PW-1:0] offset_i,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wbin_s_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rdy_o,
  output logic          ae_n_o
);
  rd_mode_e      mode_q;
  logic [PW-1:0] ofs_q;

  // Configuration captured only while the synchronized reset is held
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= RD_STD;
      ofs_q  <= '0;
    end else if (!rst_n) begin
      mode_q <= rd_mode_e'(fwft_i);
      ofs_q  <= offset_i;
    end
  end

  logic [PW-1:0] rptr_q, rptr_n, rgray_q, rgray_n, cnt, cnt_n;
  logic [DW-1:0] dout_q, dout_n;
  logic          oval_q, oval_n, flag_q, flag_n, ae_n_q, ae_n_n;
  logic          has, take, fwft;

  always_comb begin
    fwft    = (mode_q == RD_FWFT);
    cnt     = wbin_s_i - rptr_q;
    has     = (cnt != '0);
    take    = fwft ? (has && (!oval_q || rd_en_i)) : (has && rd_en_i);
    rptr_n  = rptr_q + PW'(take);
    rgray_n = (rptr_n >> 1) ^ rptr_n;
    cnt_n   = wbin_s_i - rptr_n;
    dout_n  = take ? mem_rdata_i : dout_q;
    oval_n  = fwft && (take || (oval_q && !rd_en_i));
    flag_n  = fwft ? oval_n : (cnt_n != '0);
    ae_n_n  = (cnt_n > ofs_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      oval_q  <= 1'b0;
      flag_q  <= 1'b0;
      ae_n_q  <= 1'b0;
    end else begin
      rptr_q  <= rptr_n;
      rgray_q <= rgray_n;
      dout_q  <= dout_n;
      oval_q  <= oval_n;
      flag_q  <= flag_n;
      ae_n_q  <= ae_n_n;
    end
  end

  assign raddr_o   = rptr_q[AW-1:0];
  assign rgray_o   = rgray_q;
  assign rd_data_o = dout_q;
  assign rdy_o     = flag_q;
  assign ae_n_o    = ae_n_q;

  p_ae_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ae_n_q |-> (cnt > ofs_q));
  p_std_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && flag_q) |-> has);
  p_fwft_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && $rose(oval_q)) |-> (rptr_q != $past(rptr_q)));
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !has) |=> $stable(rd_data_o));
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(mode_q) && $stable(ofs_q)));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter  int DW    = 36,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_n_i,
  input  logic          fwft_mode_i,
  input  logic [PW-1:0] ae_offset_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  output logic          overflow_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_flag_o,
  output logic          ae_n_o
);
  logic          wrst_n, rrst_n, wr_ok;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wbin_s, rbin_s;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem [DEPTH];

  dcf_rst_sync u_wrst (.clk(wclk_i), .arst_n(rst_n_i), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk_i), .arst_n(rst_n_i), .srst_n(rrst_n));

  dcf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(wclk_i), .rst_n(wrst_n), .wr_en_i(wr_en_i), .rbin_s_i(rbin_s),
    .wr_ok_o(wr_ok), .waddr_o(waddr), .wgray_o(wgray),
    .full_o(full_o), .overflow_o(overflow_o)
  );

  dcf_ptr_sync #(.W(PW)) u_r2w (
    .clk(wclk_i), .rst_n(wrst_n), .gray_i(rgray), .bin_o(rbin_s)
  );
  dcf_ptr_sync #(.W(PW)) u_w2r (
    .clk(rclk_i), .rst_n(rrst_n), .gray_i(wgray), .bin_o(wbin_s)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_ok) begin
      mem[waddr] <= wr_data_i;
    end
  end
  assign mem_rdata = mem[raddr];

  dcf_rd_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk(rclk_i), .arst_n(rst_n_i), .rst_n(rrst_n),
    .fwft_i(fwft_mode_i), .offset_i(ae_offset_i), .rd_en_i(rd_en_i),
    .wbin_s_i(wbin_s), .mem_rdata_i(mem_rdata), .raddr_o(raddr),
    .rgray_o(rgray), .rd_data_o(rd_data_o), .rdy_o(rd_flag_o), .ae_n_o(ae_n_o)
  );
endmodule

// File: tb/dcf_fifo_bench.sv
module dcf_fifo_bench;
  localparam int DW = 36;
  localparam int DEPTH = 64;
  localparam int PW = $clog2(DEPTH) + 1;

  // vector: [15] mode (1 fall-through), [14:8] offset, [7:0] words written
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{16'h0305, 16'h0809, 16'h0808, 16'h8809,
                                          16'h880A, 16'h8001, 16'h8203, 16'h0001};

  logic wclk, rclk, rst_n, fwft, wr_en, rd_en;
  logic [PW-1:0] ofs;
  logic [DW-1:0] wr_data, rd_data;
  logic full, ovf, rdy, ae_n;
  int nchk = 0, nfail = 0;
  bit done = 0;

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dcf_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_n_i(rst_n), .fwft_mode_i(fwft),
    .ae_offset_i(ofs), .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full),
    .overflow_o(ovf), .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_flag_o(rdy),
    .ae_n_o(ae_n)
  );

  initial begin wclk = 0; forever #4 wclk = ~wclk; end
  initial begin rclk = 0; #6; forever #4 rclk = ~rclk; end

  function automatic logic [DW-1:0] wd(int b, int i);
    return {4'hA, 16'(b), 16'(i)};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset(logic m, int x);
    rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    fwft = m; ofs = PW'(x);
    repeat (3) @(negedge wclk);
    rst_n = 1;
    repeat (6) @(negedge rclk);
  endtask

  task automatic write_burst(int n, int b);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); wr_en = 1; wr_data = wd(b, i);
    end
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic rd_pulse();
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    do_reset(0, 0);
    check("R10 flag", rdy, 0);
    check("R10 ae_n", ae_n, 0);
    check("R10 full", full, 0);
    check("R10 overflow", ovf, 0);
    check("R10 data", rd_data, 0);

    // Table walk: R1, R2, R5 over both modes and several offsets
    for (int v = 0; v < NVEC; v++) begin
      logic m = VEC[v][15];
      int x = int'(VEC[v][14:8]);
      int n = int'(VEC[v][7:0]);
      int acnt = m ? n - 1 : n;
      do_reset(m, x);
      write_burst(n, v);
      settle();
      check("R5 ae_n after writes", ae_n, (acnt > x) ? 1 : 0);
      check("R2/R4 flag after writes", rdy, 1);
      for (int i = 0; i < n; i++) begin
        if (m) begin
          check("R2 fall-through word", rd_data, wd(v, i));
          rd_pulse();
        end else begin
          rd_pulse();
          check("R1 standard word", rd_data, wd(v, i));
        end
      end
      check("R4/R2 flag after drain", rdy, 0);
      check("R5 ae_n after drain", ae_n, 0);
    end

    // R4 standard empty-flag timing: high on third read edge, data unchanged
    do_reset(0, 0);
    write_burst(1, 40);
    @(posedge rclk); @(posedge rclk); #1;
    check("R4 flag at edge 2", rdy, 0);
    @(posedge rclk); #1;
    check("R4 flag at edge 3", rdy, 1);
    check("R4 data before read", rd_data, 0);

    // R3 fall-through ready timing
    do_reset(1, 0);
    write_burst(1, 41);
    @(posedge rclk); @(posedge rclk); #1;
    check("R3 ready at edge 2", rdy, 0);
    @(posedge rclk); #1;
    check("R3 ready at edge 3", rdy, 1);
    check("R3 data at edge 3", rd_data, wd(41, 0));

    // R8 standard read while empty
    do_reset(0, 0);
    write_burst(1, 50);
    settle();
    rd_pulse();
    check("R8 std first read", rd_data, wd(50, 0));
    rd_pulse();
    check("R8 std read while empty", rd_data, wd(50, 0));
    check("R8 std flag", rdy, 0);

    // R8 fall-through read while not ready
    do_reset(1, 0);
    rd_pulse();
    check("R8 fwft read not ready flag", rdy, 0);
    check("R8 fwft read not ready data", rd_data, 0);
    write_burst(1, 51);
    settle();
    check("R8 fwft word shown", rd_data, wd(51, 0));
    rd_pulse();
    check("R8 fwft drained flag", rdy, 0);
    rd_pulse();
    check("R8 fwft data held", rd_data, wd(51, 0));

    // R6 reassert crossing X+1 -> X in fall-through mode (X=4)
    do_reset(1, 4);
    write_burst(7, 60);
    settle();
    check("R6 ae_n with 6 in array", ae_n, 1);
    rd_pulse();
    check("R6 data after read 1", rd_data, wd(60, 1));
    check("R6 ae_n at 5", ae_n, 1);
    rd_pulse();
    check("R6 data after read 2", rd_data, wd(60, 2));
    check("R6 ae_n at 4", ae_n, 0);

    // R6 standard mode (X=4)
    do_reset(0, 4);
    write_burst(5, 61);
    settle();
    check("R6 std ae_n at 5", ae_n, 1);
    rd_pulse();
    check("R6 std ae_n at 4", ae_n, 0);

    // R7 full and overflow
    do_reset(0, 0);
    write_burst(DEPTH, 70);
    check("R7 full at depth", full, 1);
    check("R7 no overflow yet", ovf, 0);
    write_burst(1, 71);
    check("R7 overflow set", ovf, 1);
    check("R7 still full", full, 1);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd_pulse();
      check("R7 stored word", rd_data, wd(70, i));
    end
    check("R7 dropped write not stored", rdy, 0);
    settle();
    check("R7 full cleared", full, 0);
    check("R7 overflow sticky", ovf, 1);

    // R9 configuration frozen after reset
    do_reset(0, 0);
    fwft = 1; ofs = PW'(10);
    write_burst(1, 90);
    settle();
    check("R9 mode kept standard", rd_data, 0);
    check("R9 offset kept 0", ae_n, 1);
    rd_pulse();
    check("R9 standard read", rd_data, wd(90, 0));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule